// File: doc/BRIEF.md
# Address Tenure Acquisition Controller

This block is the master side of a split-transaction address bus whose request, grant and busy lines are shared and active-low. An internal client holds `req_i` high while it wants an address tenure. The controller raises the bus request, decides each cycle whether the grant it sees is qualified, and takes the address bus when it is. It then holds address-bus-busy asserted until the address acknowledge arrives.

After the acknowledge, the busy line is driven to its inactive level for a short release window and then let go; an external pull-up keeps it high from then on. The first cycle after the acknowledge is also the only cycle in which address retry counts. A retry sends the controller back to requesting, with the client's request still in place. A tenure that ends without retry gives the client a one-cycle `done_o` pulse.

The controller can take the bus without ever raising a request when the arbiter has parked the grant on it. It honours a grant that was qualified in the previous cycle even if the grant has since been withdrawn. Dropping `req_i` cancels any ownership not yet taken.

Top module: `addr_tenure_ctl`

## Requirements
- R1: While `rst_i` is high at a clock edge, the outputs after that edge are `br_n_o`=1, `abb_oe_o`=0, `abb_n_o`=1 and `done_o`=0.
- R2: If `req_i` is 1 in an idle or requesting cycle and ownership is not taken, `br_n_o` is 0 from the next cycle. It returns to 1 in the cycle after ownership is taken, or in the cycle after `req_i` is seen at 0.
- R3: A grant is qualified in a cycle when `bg_n_i`=0, `abb_n_i`=1 and no retry block applies. If `req_i`=1 in that cycle, `abb_n_o`=0 and `abb_oe_o`=1 from the next cycle. A busy line held low by another master prevents ownership.
- R4: `artry_n_i`=0 blocks qualification only in the cycle right after a cycle with `aack_n_i`=0. In every other cycle it has no effect on taking the bus.
- R5: Ownership can be taken from the idle state with `br_n_o` staying 1 throughout, when the grant is parked on this master.
- R6: If `req_i` is 0 in a cycle where the grant is qualified, ownership is not taken and `abb_oe_o` stays 0.
- R7: If the grant was qualified in the previous cycle, ownership is taken in a cycle with `req_i`=1 even if `bg_n_i` is now 1.
- R8: While this master owns the bus, `abb_n_o`=0 with `abb_oe_o`=1 is held every cycle until `aack_n_i`=0 is seen, whatever `bg_n_i` does.
- R9: From the cycle after `aack_n_i`=0, the output drives `abb_n_o`=1 with `abb_oe_o`=1 for `RELEASE_CYCLES` cycles. `abb_oe_o` is 0 in the following cycle.
- R10: If `artry_n_i`=0 in the first cycle after the acknowledge, no `done_o` is given. When the release window ends, the controller returns to requesting (`br_n_o`=0) if `req_i`=1, and to idle otherwise.
- R11: A tenure that ends without retry raises `done_o` for exactly one cycle, the cycle after the release window. No ownership is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Internal tenure request, level; low cancels |
| done_o | output | 1 | One-cycle pulse when a tenure completes without retry |
| br_n_o | output | 1 | Bus request, active low |
| bg_n_i | input | 1 | Bus grant, active low |
| abb_n_i | input | 1 | Observed address-bus-busy line, active low |
| abb_n_o | output | 1 | Address-bus-busy drive value, active low |
| abb_oe_o | output | 1 | Output enable for the busy drive |
| aack_n_i | input | 1 | Address acknowledge, active low |
| artry_n_i | input | 1 | Address retry, active low |

## Verification
The bench builds the block with `RELEASE_CYCLES`=1, which is the default. With this value the release cycle is the same cycle as the retry window. Completion, retry and the busy hand-back therefore follow each other in back-to-back cycles, and each edge of that sequence can be hit directly. The bench models the shared busy line as a wired line with a pull-up that another master can pull low, so both the busy-line block and the retry block on qualification come within reach of random traffic.

// File: rtl/addr_tenure_pkg.sv
package addr_tenure_pkg;

    // Phases of one address tenure as seen from this master.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_OWN  = 2'd2,
        ST_REL  = 2'd3
    } tenure_st_e;

endpackage

// File: rtl/tenure_grant_qual.sv
module tenure_grant_qual (
    input  logic clk_i,
    input  logic rst_i,
    input  logic bg_n_i,
    input  logic abb_n_i,
    input  logic aack_n_i,
    input  logic artry_n_i,
    output logic grant_o
);

    typedef struct packed {
        logic aack_prev;   // acknowledge seen in the previous cycle
        logic qual_prev;   // grant was qualified in the previous cycle
    } qual_regs_t;

    qual_regs_t r_d, r_q;
    logic       retry_block;
    logic       qual_now;

    always_comb begin
        // Retry only counts in the cycle right after an acknowledge.
        retry_block = r_q.aack_prev & ~artry_n_i;
        qual_now    = ~bg_n_i & abb_n_i & ~retry_block;
        r_d.aack_prev = ~aack_n_i;
        r_d.qual_prev = qual_now;
        // A grant withdrawn this cycle still counts if it qualified last cycle.
        grant_o = qual_now | r_q.qual_prev;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/tenure_fsm.sv
module tenure_fsm
    import addr_tenure_pkg::*;
#(
    parameter int RELEASE_CYCLES = 1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic req_i,
    input  logic grant_i,
    input  logic aack_n_i,
    input  logic artry_n_i,
    output logic br_n_o,
    output logic abb_n_o,
    output logic abb_oe_o,
    output logic done_o
);

    localparam int CNT_W = (RELEASE_CYCLES > 1) ? $clog2(RELEASE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RELEASE_CYCLES - 1);

    typedef struct packed {
        tenure_st_e       st;
        logic [CNT_W-1:0] cnt;
        logic             retry;
        logic             br_n;
        logic             abb_n;
        logic             oe;
        logic             done;
    } fsm_regs_t;

    fsm_regs_t s_d, s_q;
    logic      take;
    logic      retry_now;

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        retry_now = 1'b0;
        // No new tenure in the cycle that reports completion.
        take = req_i & grant_i & ~s_q.done;

        unique case (s_q.st)
            ST_IDLE, ST_REQ: begin
                if (take) begin
                    s_d.st    = ST_OWN;
                    s_d.br_n  = 1'b1;
                    s_d.abb_n = 1'b0;
                    s_d.oe    = 1'b1;
                end else if (req_i) begin
                    s_d.st   = ST_REQ;
                    s_d.br_n = 1'b0;
                end else begin
                    s_d.st   = ST_IDLE;
                    s_d.br_n = 1'b1;
                end
            end
            ST_OWN: begin
                if (!aack_n_i) begin
                    s_d.st    = ST_REL;
                    s_d.cnt   = '0;
                    s_d.retry = 1'b0;
                    s_d.abb_n = 1'b1;
                    s_d.oe    = 1'b1;
                end
            end
            ST_REL: begin
                retry_now = s_q.retry | ((s_q.cnt == '0) & ~artry_n_i);
                s_d.retry = retry_now;
                if (s_q.cnt == LAST) begin
                    s_d.oe    = 1'b0;
                    s_d.retry = 1'b0;
                    s_d.cnt   = '0;
                    if (retry_now) begin
                        if (req_i) begin
                            s_d.st   = ST_REQ;
                            s_d.br_n = 1'b0;
                        end else begin
                            s_d.st = ST_IDLE;
                        end
                    end else begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q.st    <= ST_IDLE;
            s_q.cnt   <= '0;
            s_q.retry <= 1'b0;
            s_q.br_n  <= 1'b1;
            s_q.abb_n <= 1'b1;
            s_q.oe    <= 1'b0;
            s_q.done  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign br_n_o   = s_q.br_n;
    assign abb_n_o  = s_q.abb_n;
    assign abb_oe_o = s_q.oe;
    assign done_o   = s_q.done;

endmodule

// File: rtl/addr_tenure_ctl.sv
module addr_tenure_ctl #(
    parameter int RELEASE_CYCLES = 1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic req_i,
    output logic done_o,
    output logic br_n_o,
    input  logic bg_n_i,
    input  logic abb_n_i,
    output logic abb_n_o,
    output logic abb_oe_o,
    input  logic aack_n_i,
    input  logic artry_n_i
);

    logic grant;

    tenure_grant_qual u_qual (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .bg_n_i    (bg_n_i),
        .abb_n_i   (abb_n_i),
        .aack_n_i  (aack_n_i),
        .artry_n_i (artry_n_i),
        .grant_o   (grant)
    );

    tenure_fsm #(
        .RELEASE_CYCLES (RELEASE_CYCLES)
    ) u_fsm (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .req_i     (req_i),
        .grant_i   (grant),
        .aack_n_i  (aack_n_i),
        .artry_n_i (artry_n_i),
        .br_n_o    (br_n_o),
        .abb_n_o   (abb_n_o),
        .abb_oe_o  (abb_oe_o),
        .done_o    (done_o)
    );

endmodule

// File: rtl/addr_tenure_ctl_chk.sv
module addr_tenure_ctl_chk (
    input logic clk_i,
    input logic rst_i,
    input logic req_i,
    input logic done_o,
    input logic br_n_o,
    input logic abb_n_o,
    input logic abb_oe_o,
    input logic aack_n_i
);

    // R1: reset leaves the bus lines released
    p_reset_state_r1: assert property (@(posedge clk_i)
        rst_i |=> (br_n_o && !abb_oe_o && !done_o));

    // R2: no bus request while busy is asserted by this master
    p_no_req_when_owner_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (abb_oe_o && !abb_n_o) |-> br_n_o);

    // R6: ownership starts only after a cycle with the request present
    p_take_needs_req_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(abb_oe_o) |-> ($past(req_i) && !abb_n_o));

    // R8: busy held until the acknowledge
    p_busy_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (abb_oe_o && !abb_n_o && aack_n_i) |=> (abb_oe_o && !abb_n_o));

    // R9: busy driven inactive right after the acknowledge
    p_release_drive_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (abb_oe_o && !abb_n_o && !aack_n_i) |=> (abb_oe_o && abb_n_o));

    // R11: completion is a single-cycle pulse with the line released
    p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);

    p_done_released_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> !abb_oe_o);

endmodule

bind addr_tenure_ctl addr_tenure_ctl_chk u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .req_i    (req_i),
    .done_o   (done_o),
    .br_n_o   (br_n_o),
    .abb_n_o  (abb_n_o),
    .abb_oe_o (abb_oe_o),
    .aack_n_i (aack_n_i)
);

// File: tb/sim_addr_tenure_ctl.sv
`timescale 1ns/1ps
module sim_addr_tenure_ctl;

    localparam int RC = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic bg_n = 1'b1;
    logic aack_n = 1'b1;
    logic artry_n = 1'b1;
    logic oth = 1'b0;
    logic done, br_n, abb_n_o, abb_oe;
    logic abb_line;

    // Wired busy line: this master when enabled, else other master or pull-up.
    assign abb_line = abb_oe ? abb_n_o : ~oth;

    always #2.5 clk = ~clk;

    addr_tenure_ctl #(.RELEASE_CYCLES(RC)) u0 (
        .clk_i     (clk),
        .rst_i     (rst),
        .req_i     (req),
        .done_o    (done),
        .br_n_o    (br_n),
        .bg_n_i    (bg_n),
        .abb_n_i   (abb_line),
        .abb_n_o   (abb_n_o),
        .abb_oe_o  (abb_oe),
        .aack_n_i  (aack_n),
        .artry_n_i (artry_n)
    );

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 0;

    // Reference model state (0 idle, 1 requesting, 2 owning, 3 releasing)
    int  m_st, m_cnt;
    bit  m_retry, m_br, m_abb, m_oe, m_done, m_aprev, m_qprev;

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        m_st = 0; m_cnt = 0; m_retry = 0; m_br = 1; m_abb = 1;
        m_oe = 0; m_done = 0; m_aprev = 0; m_qprev = 0;
    endfunction

    // Drive one cycle of inputs, advance the model, compare after the edge.
    task automatic step(input bit r, input bit b, input bit a, input bit t, input bit o);
        bit line, qn, g, tk, rn;
        int n_st, n_cnt;
        bit n_retry, n_br, n_abb, n_oe, n_done;
        req = r; bg_n = b; aack_n = a; artry_n = t; oth = o;
        line = abb_oe ? abb_n_o : !o;
        qn = !b && line && !(m_aprev && !t);
        g  = qn || m_qprev;
        tk = r && g && !m_done;
        n_st = m_st; n_cnt = m_cnt; n_retry = m_retry; n_br = m_br;
        n_abb = m_abb; n_oe = m_oe; n_done = 0;
        case (m_st)
            0, 1: begin
                if (tk) begin n_st = 2; n_br = 1; n_abb = 0; n_oe = 1; end
                else if (r) begin n_st = 1; n_br = 0; end
                else begin n_st = 0; n_br = 1; end
            end
            2: if (!a) begin n_st = 3; n_cnt = 0; n_retry = 0; n_abb = 1; n_oe = 1; end
            default: begin
                rn = m_retry || (m_cnt == 0 && !t);
                n_retry = rn;
                if (m_cnt == RC - 1) begin
                    n_oe = 0; n_retry = 0; n_cnt = 0;
                    if (rn) begin
                        if (r) begin n_st = 1; n_br = 0; end else n_st = 0;
                    end else begin
                        n_st = 0; n_done = 1;
                    end
                end else n_cnt = m_cnt + 1;
            end
        endcase
        m_aprev = !a; m_qprev = qn;
        @(posedge clk);
        @(negedge clk);
        m_st = n_st; m_cnt = n_cnt; m_retry = n_retry; m_br = n_br;
        m_abb = n_abb; m_oe = n_oe; m_done = n_done;
        chk("R2", br_n, m_br);
        chk("R3", abb_n_o, m_abb);
        chk("R9", abb_oe, m_oe);
        chk("R11", done, m_done);
    endtask

    task automatic finish_tenure();
        step(0, 1, 0, 1, 0);
        step(0, 1, 1, 1, 0);
        step(0, 1, 1, 1, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", br_n, 1'b1);
        chk("R1", abb_oe, 1'b0);
        chk("R1", abb_n_o, 1'b1);
        chk("R1", done, 1'b0);
        rst = 1'b0;
        model_reset();

        // Request, grant, tenure, clean completion
        step(1, 1, 1, 1, 0);  chk("R2", br_n, 1'b0);
        step(1, 0, 1, 1, 0);  chk("R3", abb_oe, 1'b1); chk("R3", abb_n_o, 1'b0); chk("R2", br_n, 1'b1);
        step(1, 1, 1, 0, 0);  chk("R8", abb_n_o, 1'b0); chk("R4", abb_oe, 1'b1);
        step(0, 0, 1, 1, 0);  chk("R8", abb_n_o, 1'b0);
        step(0, 1, 0, 1, 0);  chk("R9", abb_oe, 1'b1); chk("R9", abb_n_o, 1'b1);
        step(0, 1, 1, 1, 0);  chk("R9", abb_oe, 1'b0); chk("R11", done, 1'b1);
        step(0, 1, 1, 1, 0);  chk("R11", done, 1'b0);

        // R5: parked grant, no request raised; then R10 retry
        step(1, 0, 1, 1, 0);  chk("R5", br_n, 1'b1); chk("R5", abb_oe, 1'b1);
        step(1, 1, 0, 1, 0);
        step(1, 1, 1, 0, 0);  chk("R10", br_n, 1'b0); chk("R10", done, 1'b0); chk("R10", abb_oe, 1'b0);
        step(0, 1, 1, 1, 0);  chk("R2", br_n, 1'b1);

        // R6: cancelled in the qualifying cycle
        step(1, 1, 1, 1, 0);
        step(0, 0, 1, 1, 0);  chk("R6", abb_oe, 1'b0);
        step(0, 1, 1, 1, 0);  chk("R6", abb_oe, 1'b0);

        // R7: grant withdrawn, but qualified one cycle earlier
        step(0, 0, 1, 1, 0);
        step(1, 1, 1, 1, 0);  chk("R7", abb_oe, 1'b1); chk("R7", abb_n_o, 1'b0);
        finish_tenure();

        // R4: retry blocks only right after another master's acknowledge
        step(0, 1, 0, 1, 1);
        step(1, 0, 1, 0, 0);  chk("R4", abb_oe, 1'b0);
        step(1, 0, 1, 0, 0);  chk("R4", abb_oe, 1'b1);
        finish_tenure();

        // R3: busy line held by another master blocks the grant
        step(1, 0, 1, 1, 1);  chk("R3", abb_oe, 1'b0);
        step(1, 0, 1, 1, 0);  chk("R3", abb_oe, 1'b1);
        finish_tenure();

        // Constrained random traffic checked against the model
        for (int i = 0; i < 4000; i++) begin
            bit r, b, a, t, o;
            r = ($urandom % 4) != 0;
            b = ($urandom % 2) != 0;
            a = ($urandom % 5) != 0;
            t = ($urandom % 4) != 0;
            o = ($urandom % 6) == 0;
            step(r, b, a, t, o);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule